// File: doc/BRIEF.md
# Daisy-Chained Pixel Serial Receiver

This block is the serial front end of one node in a chain of three-channel LED drivers. A controller streams bits on a data line, and each bit is marked by a one-cycle `shift_tick` that stands for a rising edge of the shift clock. A run of 32 zero bits works as a marker that rearms every node. The first 16-bit pixel frame after the marker belongs to this node. A frame is a leading 1 followed by three 5-bit grey codes. The node replaces its own frame with zeros on the downstream line and passes every later bit on, one tick late. The shift tick is passed on as a registered copy.

The captured codes do not reach the display registers until the controller has sent all frames and starts the trailing append clocks, which carry zero data. The node commits at the first frame boundary whose start-bit slot holds a 0, and it raises `commit_pulse` for one cycle.

The controller has four states. `ST_HUNT` is the state after reset: it forwards bits and captures nothing. `ST_GRAB` skips extra marker zeros, waits for the start bit and then shifts in the payload. `ST_FORWARD` passes downstream frames on and watches each frame boundary. `ST_SETTLED` is reached after the commit and forwards everything. The transitions are as follows:
- marker-hit: any state moves to `ST_GRAB`.
- payload-done: `ST_GRAB` moves to `ST_FORWARD` after the 16th frame bit.
- boundary-zero: `ST_FORWARD` moves to `ST_SETTLED`, and this move is the commit.

Top module: `pixel_chain_rx`

## Requirements
- R1: After reset the three colour codes are 0, `dout`, `commit_pulse` and `shift_tick_out` are 0, and the node is in the hunting state, where it forwards bits and captures none.
- R2: 32 consecutive zero bits sampled on ticks arm the node for capture from any state. A 1 clears the run, so a run of 31 zeros followed by a frame arms nothing, and that frame is forwarded without being captured.
- R3: Once the node is armed, further zero bits in the start-bit slot are skipped. The first 1 sampled begins the node's own frame.
- R4: A frame is one start bit of 1 followed by 15 payload bits, sent most significant bit first. Payload bits 14..10 are red, bits 9..5 are green and bits 4..0 are blue.
- R5: During the node's own 16 frame bits, `dout` is driven to 0 after every tick.
- R6: Outside the node's own frame, `dout` takes the value of `din` sampled at each tick, one cycle after that tick. `dout` holds that value until the next tick.
- R7: After its own frame, the node counts bits in frames of 16. At the first boundary slot that samples a 0, it loads the captured codes into the colour outputs, and `commit_pulse` is 1 for exactly the one cycle after that tick.
- R8: The colour outputs change only at a commit. They do not change while the node captures its own frame or while downstream frames pass through.
- R9: `shift_tick_out` equals `shift_tick` delayed by one clock cycle.
- R10: After a commit the node captures nothing and forwards all bits, including frames, until a new marker rearms it. A new marker, a frame and an append bit then replace the colour codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_tick | input | 1 | One-cycle strobe, one per rising edge of the shift clock |
| din | input | 1 | Serial data, sampled when `shift_tick` is 1 |
| dout | output | 1 | Serial data to the next node |
| shift_tick_out | output | 1 | Registered copy of `shift_tick` for the next node |
| red_code | output | 5 | Committed red grey code |
| green_code | output | 5 | Committed green grey code |
| blue_code | output | 5 | Committed blue grey code |
| commit_pulse | output | 1 | One-cycle strobe when new codes take effect |

## Verification
The bench sends 31 zeros before a frame, to catch an off-by-one marker counter that would capture a frame it should forward. It also sends extra marker zeros before the start bit; a design that did not skip them would shift them into the payload and get the colours wrong. A chained test with two downstream frames checks that commit waits for the boundary zero: a node that committed at the end of its own frame, or that lost count of frame boundaries, would pulse early or miss the pulse. After a commit, frames are sent with no marker; a node that kept capturing would change its colours without being rearmed.

// File: rtl/pixel_chain_pkg.sv
package pixel_chain_pkg;

    // Controller states of one chain node
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,  // after reset: forward, capture nothing
        ST_GRAB    = 2'd1,  // armed: wait for start bit, then take payload
        ST_FORWARD = 2'd2,  // own frame held, watch downstream boundaries
        ST_SETTLED = 2'd3   // committed: forward until re-armed
    } rx_state_e;

    // Number of colour channels carried per frame
    localparam int NUM_CH = 3;

endpackage

// File: rtl/pcr_zero_run.sv
module pcr_zero_run #(
    parameter int MARK_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bit_in,
    output logic marker_hit
);
    localparam int CNT_W = $clog2(MARK_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MARK_LEN);
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_W'(MARK_LEN - 1);

    logic [CNT_W-1:0] run_q;

    // Saturating count of consecutive zero samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (tick) begin
            if (bit_in)
                run_q <= '0;
            else if (run_q != CNT_MAX)
                run_q <= run_q + 1'b1;
        end
    end

    // The current zero completes (or extends) a full marker
    assign marker_hit = tick && !bit_in && (run_q >= CNT_NEAR);

    AST_ONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && bit_in) |=> (run_q == '0)) else $error("run not cleared"); // R2

    AST_ZERO_GROWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !bit_in && run_q < CNT_MAX) |=> (run_q == $past(run_q) + 1'b1))
        else $error("run did not grow"); // R2

endmodule

// File: rtl/pcr_ctrl.sv
module pcr_ctrl
    import pixel_chain_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      bit_in,
    input  logic      marker_hit,
    output rx_state_e state,
    output logic      cap_en,
    output logic      pass_en,
    output logic      commit_now
);
    localparam int IDX_W = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    rx_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // State register with bit position inside the current frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Transitions: marker-hit, payload-done, boundary-zero
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (tick) begin
            if (marker_hit) begin
                state_d = ST_GRAB;
                idx_d   = '0;
            end else begin
                unique case (state_q)
                    ST_HUNT: begin
                        idx_d = '0;
                    end
                    ST_GRAB: begin
                        if (idx_q == '0) begin
                            if (bit_in) idx_d = 1'b1;
                        end else if (idx_q == LAST_IDX) begin
                            state_d = ST_FORWARD;
                            idx_d   = '0;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                    ST_FORWARD: begin
                        if (idx_q == '0 && !bit_in) begin
                            state_d = ST_SETTLED;
                            idx_d   = '0;
                        end else if (idx_q == LAST_IDX) begin
                            idx_d = '0;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                    ST_SETTLED: begin
                        idx_d = '0;
                    end
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        cap_en     = 1'b0;
        pass_en    = 1'b1;
        commit_now = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                pass_en = 1'b1;
            end
            ST_GRAB: begin
                pass_en = 1'b0;
                cap_en  = tick && !marker_hit && (idx_q != '0);
            end
            ST_FORWARD: begin
                commit_now = tick && !marker_hit && (idx_q == '0) && !bit_in;
            end
            ST_SETTLED: begin
                pass_en = 1'b1;
            end
        endcase
    end

    assign state = state_q;

    AST_MARKER_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && marker_hit) |=> (state_q == ST_GRAB)) else $error("marker ignored"); // R2

    AST_START_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == ST_GRAB && idx_q == '0 && !bit_in)
        |=> (state_q == ST_GRAB && idx_q == '0)) else $error("zero taken as start"); // R3

    AST_PAYLOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !marker_hit && state_q == ST_GRAB && idx_q == LAST_IDX)
        |=> (state_q == ST_FORWARD)) else $error("frame end missed"); // R4

    AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLED && !(tick && marker_hit)) |=> (state_q == ST_SETTLED))
        else $error("left settled without marker"); // R10

endmodule

// File: rtl/pcr_pixel_store.sv
module pcr_pixel_store
    import pixel_chain_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              bit_in,
    input  logic              commit_now,
    output logic [CODE_W-1:0] codes [NUM_CH],
    output logic              commit_q
);
    localparam int PAY_W = NUM_CH * CODE_W;

    logic [PAY_W-1:0] shadow_q;
    logic [PAY_W-1:0] disp_q;

    // Shadow shifts MSB first; display loads only at commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            disp_q   <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= commit_now;
            if (cap_en)
                shadow_q <= {shadow_q[PAY_W-2:0], bit_in};
            if (commit_now)
                disp_q <= shadow_q;
        end
    end

    // Channel 0 (red) sits at the top of the payload
    for (genvar k = 0; k < NUM_CH; k++) begin : g_slice
        assign codes[k] = disp_q[PAY_W-1-k*CODE_W -: CODE_W];
    end

    AST_DISPLAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_now |=> $stable(disp_q)) else $error("display moved w/o commit"); // R8

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> !commit_q) else $error("commit longer than one cycle"); // R7

    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_now |=> (disp_q == $past(shadow_q))) else $error("commit load wrong"); // R7

endmodule

// File: rtl/pixel_chain_rx.sv
module pixel_chain_rx
    import pixel_chain_pkg::*;
#(
    parameter int CODE_W   = 5,
    parameter int MARK_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_tick,
    input  logic              din,
    output logic              dout,
    output logic              shift_tick_out,
    output logic [CODE_W-1:0] red_code,
    output logic [CODE_W-1:0] green_code,
    output logic [CODE_W-1:0] blue_code,
    output logic              commit_pulse
);
    localparam int FRAME_W = 1 + NUM_CH * CODE_W;

    rx_state_e         state;
    logic              marker_hit;
    logic              cap_en;
    logic              pass_en;
    logic              commit_now;
    logic [CODE_W-1:0] codes [NUM_CH];

    pcr_zero_run #(.MARK_LEN(MARK_LEN)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (shift_tick),
        .bit_in     (din),
        .marker_hit (marker_hit)
    );

    pcr_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (shift_tick),
        .bit_in     (din),
        .marker_hit (marker_hit),
        .state      (state),
        .cap_en     (cap_en),
        .pass_en    (pass_en),
        .commit_now (commit_now)
    );

    pcr_pixel_store #(.CODE_W(CODE_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .bit_in     (din),
        .commit_now (commit_now),
        .codes      (codes),
        .commit_q   (commit_pulse)
    );

    // Downstream data and regenerated tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout           <= 1'b0;
            shift_tick_out <= 1'b0;
        end else begin
            shift_tick_out <= shift_tick;
            if (shift_tick)
                dout <= pass_en ? din : 1'b0;
        end
    end

    assign red_code   = codes[0];
    assign green_code = codes[1];
    assign blue_code  = codes[2];

    AST_OWN_FRAME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_tick && state == ST_GRAB) |=> !dout) else $error("own bit leaked"); // R5

    AST_PASS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_tick && state != ST_GRAB) |=> (dout == $past(din))) else $error("forward wrong"); // R6

    AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_tick |=> $stable(dout)) else $error("dout moved between ticks"); // R6

    AST_TICK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (shift_tick_out == $past(shift_tick))) else $error("tick copy wrong"); // R9

endmodule

// File: tb/pixel_chain_rx_tb.sv
module pixel_chain_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_tick = 1'b0;
    logic       din = 1'b0;
    logic       dout, shift_tick_out, commit_pulse;
    logic [4:0] red_code, green_code, blue_code;

    int n_chk = 0;
    int n_bad = 0;
    int n_commit = 0;
    int tick_errs = 0;
    logic o_dout, o_dout2;

    always #4 clk = ~clk;

    pixel_chain_rx u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .shift_tick     (shift_tick),
        .din            (din),
        .dout           (dout),
        .shift_tick_out (shift_tick_out),
        .red_code       (red_code),
        .green_code     (green_code),
        .blue_code      (blue_code),
        .commit_pulse   (commit_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One bit: tick cycle, then one idle cycle; samples at negedges
    task automatic send_bit(input logic b);
        @(negedge clk);
        din = b;
        shift_tick = 1'b1;
        @(negedge clk);
        shift_tick = 1'b0;
        o_dout = dout;
        if (shift_tick_out !== 1'b1) tick_errs++;
        n_commit += int'(commit_pulse);
        @(negedge clk);
        o_dout2 = dout;
        if (shift_tick_out !== 1'b0) tick_errs++;
        n_commit += int'(commit_pulse);
    endtask

    task automatic send_zeros(input int n, input bit chk_out);
        for (int i = 0; i < n; i++) begin
            send_bit(1'b0);
            if (chk_out) chk("R6 zero forwarded", int'(o_dout), 0);
        end
    endtask

    // mode 0: expect dropped (R5); mode 1: expect forwarded (R6)
    task automatic send_frame(input logic [4:0] r, input logic [4:0] g,
                              input logic [4:0] b, input int mode);
        logic [15:0] w;
        w = {1'b1, r, g, b};
        for (int i = 15; i >= 0; i--) begin
            send_bit(w[i]);
            if (mode == 0) begin
                chk("R5 own frame dropped", int'(o_dout), 0);
            end else begin
                chk("R6 bit forwarded", int'(o_dout), int'(w[i]));
                chk("R6 dout held", int'(o_dout2), int'(w[i]));
            end
        end
    endtask

    task automatic chk_colours(input string req, input int r, input int g, input int b);
        chk({req, " red"},   int'(red_code),   r);
        chk({req, " green"}, int'(green_code), g);
        chk({req, " blue"},  int'(blue_code),  b);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_colours("R1 reset", 0, 0, 0);
        chk("R1 reset dout", int'(dout), 0);
        chk("R1 reset commit", int'(commit_pulse), 0);
        chk("R1 reset tick out", int'(shift_tick_out), 0);
    endtask

    // 31 zeros are not a marker: frame passes through, nothing commits
    task automatic t_short_marker();
        n_commit = 0;
        send_zeros(31, 1'b1);
        send_frame(5'd9, 5'd4, 5'd2, 1);
        send_bit(1'b0);
        chk("R2 short marker no commit", n_commit, 0);
        chk_colours("R2 short marker colours", 0, 0, 0);
    endtask

    // Single node: marker, extra zeros, own frame, one append bit
    task automatic t_single();
        n_commit = 0;
        tick_errs = 0;
        send_zeros(32, 1'b1);
        send_zeros(3, 1'b1);          // R3 extra zeros skipped
        send_frame(5'h15, 5'h0A, 5'h1F, 0);
        chk_colours("R8 no change before append", 0, 0, 0);
        chk("R8 no commit before append", n_commit, 0);
        send_bit(1'b0);
        chk("R7 commit after append", n_commit, 1);
        chk_colours("R4 R3 field order", 5'h15, 5'h0A, 5'h1F);
        chk("R9 tick copy", tick_errs, 0);
    endtask

    // Chain: own frame then two downstream frames, then appends
    task automatic t_chain();
        n_commit = 0;
        send_zeros(32, 1'b1);
        send_frame(5'd3, 5'd17, 5'd30, 0);
        send_frame(5'd1, 5'd0, 5'd31, 1);
        chk_colours("R8 held during downstream", 5'h15, 5'h0A, 5'h1F);
        send_frame(5'd0, 5'd0, 5'd0, 1);
        chk("R7 no early commit", n_commit, 0);
        chk_colours("R8 held before boundary zero", 5'h15, 5'h0A, 5'h1F);
        send_zeros(3, 1'b1);
        chk("R7 exactly one commit", n_commit, 1);
        chk_colours("R7 chained colours", 3, 17, 30);
    endtask

    // After commit: frames pass through uncaptured until a new marker
    task automatic t_rearm();
        n_commit = 0;
        send_frame(5'd7, 5'd7, 5'd7, 1);
        send_bit(1'b0);
        chk("R10 no capture when settled", n_commit, 0);
        chk_colours("R10 colours kept", 3, 17, 30);
        send_zeros(32, 1'b1);
        send_frame(5'd31, 5'd16, 5'd1, 0);
        send_bit(1'b0);
        chk("R10 rearm commit", n_commit, 1);
        chk_colours("R10 rearmed colours", 31, 16, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_short_marker();
        t_single();
        t_chain();
        t_rearm();
        finish_run();
    end
endmodule